// File: doc/BRIEF.md
# Data Watchpoint Address Matcher

This block holds a bank of hardware data watchpoints and tests every data access against all of them in parallel. Each watchpoint owns a 32-bit watched address and a 32-bit control word. Software writes and reads both through one indexed register port. A kind select picks the address or the control word, and an index picks the watchpoint.

For each access the block receives the byte address, a size code, a store flag and a one-bit privilege tag. One clock later it presents a hit vector with one bit per watchpoint and a flag that is set when any bit of the vector is set. A watchpoint can match an exact window of bytes inside one double-word, or an aligned power-of-two region from 8 bytes up to 2 GiB. Enable, access direction and privilege level qualify each watchpoint. Any reserved control encoding turns the watchpoint off.

The parameter `SUPPORT_MASK` selects the region compare at elaboration. When it is 0, any nonzero mask value disables the watchpoint.

Top module: `dwb_bank`

## Requirements
- R1: After reset, every watched address and control word reads back as zero and no access produces a hit.
- R2: A control write keeps bits 28:24 and 20:0 and forces bits 31:29 and 23:21 to zero on read-back. A watched-address write reads back unchanged. Register kind 0 is the address and kind 1 is the control word.
- R3: When the control enable bit (bit 0) is 0, the watchpoint never hits, whatever its other fields hold.
- R4: With mask field (bits 28:24) equal to 0, a hit requires access address bits 31:3 to equal watched address bits 31:3, and at least one byte the access touches must be a selected lane. Byte-select bit i (control bit 5+i) selects byte i of the double-word. An access of size code s (0..3) touches 2^s bytes starting at address bits 2:0, limited to that double-word.
- R5: When watched address bit 2 is 1, only byte-select bits 3:0 take part, and they select bytes 4 to 7. Byte-select bits 7:4 are ignored.
- R6: With mask 0, a byte-select value that is zero or has non-contiguous set bits disables the watchpoint. The value judged is the full field, or bits 3:0 when watched address bit 2 is 1.
- R7: A mask value k from 3 to 31 makes the watchpoint hit whenever address bits 31:k equal watched address bits 31:k. Byte select takes no part.
- R8: Mask values 1 and 2 disable the watchpoint, and the written value still reads back unchanged.
- R9: In the load/store field (bits 4:3), bit 3 enables loads and bit 4 enables stores. The value 00 never hits.
- R10: Privilege control bit 1 enables hits for unprivileged accesses (tag 0), and bit 2 enables hits for privileged accesses (tag 1).
- R11: The hit vector and the any-hit flag are registered one cycle after the access strobe and are zero in a cycle that follows no strobe. The any-hit flag is the OR of the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_kind | input | 1 | 0 = watched address, 1 = control word |
| reg_idx | input | IDX_W | Watchpoint index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for kind/index (combinational) |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 32 | Access byte address |
| acc_size | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_priv | input | 1 | 1 = privileged access |
| hit_vec | output | NUM_WP | Registered per-watchpoint hit |
| hit_any | output | 1 | Registered OR of the hit vector |

## Verification
The bench aims at the lane-overlap edges. A one-byte access just past the selected window must miss, and an access that straddles into the window must hit. A matcher that compares whole words or ignores the offset would report hits on neighbouring bytes. Watched addresses with bit 2 set are checked to make sure the upper lane bits are ignored and the low lanes are shifted up. A design that skipped this would fire on the wrong half of the double-word. The bench also checks the region boundaries at mask 12 and mask 31, where an off-by-one shift would accept the first address outside the region. Reserved masks, byte selects that are empty or have gaps, and load/store 00 must all stay silent while the written value still reads back.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

   localparam int WORD_W = 32;
   localparam int LANES  = 8;

   // control word layout; the matcher decodes these positions
   typedef struct packed {
      logic [2:0]       zero_hi;
      logic [4:0]       mask;
      logic [2:0]       zero_mid;
      logic             link_type;
      logic [3:0]       link_idx;
      logic [1:0]       sec_ctl;
      logic             hi_mode;
      logic [LANES-1:0] lane_sel;
      logic [1:0]       ldst;
      logic [1:0]       priv_en;
      logic             en;
   } wctl_t;

   localparam logic [WORD_W-1:0] CTL_KEEP = 32'h1F1F_FFFF;

   // nonzero and one contiguous run of ones
   function automatic logic lanes_valid(input logic [LANES-1:0] b);
      logic [LANES-1:0] low;
      logic [LANES:0]   sum;
      low = b & (~b + 1'b1);
      sum = {1'b0, b} + {1'b0, low};
      return (b != '0) && ((sum[LANES-1:0] & b) == '0);
   endfunction

   // byte lanes of a double-word touched by an access
   function automatic logic [LANES-1:0] touched_lanes(input logic [1:0] size,
                                                     input logic [2:0] off);
      logic [LANES-1:0]   fill;
      logic [2*LANES-2:0] wide;
      case (size)
         2'd0:    fill = 8'h01;
         2'd1:    fill = 8'h03;
         2'd2:    fill = 8'h0F;
         default: fill = 8'hFF;
      endcase
      wide = {{(LANES-1){1'b0}}, fill} << off;
      return wide[LANES-1:0];
   endfunction

endpackage

// File: rtl/dwb_regs.sv
module dwb_regs #(
   parameter int NUM_WP = 16,
   parameter int IDX_W  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic                        kind,
   input  logic [IDX_W-1:0]            idx,
   input  logic [31:0]                 wdata,
   output logic [31:0]                 rdata,
   output logic [NUM_WP-1:0][31:0]     val_q,
   output logic [NUM_WP-1:0][31:0]     ctl_q
);
   import dwb_pkg::*;

   for (genvar g = 0; g < NUM_WP; g++) begin : g_slot
      logic hit_idx;
      assign hit_idx = (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q[g] <= '0;
            ctl_q[g] <= '0;
         end else if (we && hit_idx) begin
            if (kind) ctl_q[g] <= wdata & CTL_KEEP;
            else      val_q[g] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_WP; i++) begin
         if (idx == IDX_W'(i)) rdata = kind ? ctl_q[i] : val_q[i];
      end
   end

endmodule

// File: rtl/dwb_slot.sv
module dwb_slot #(
   parameter bit SUPPORT_MASK = 1'b1
) (
   input  logic [31:0] val,
   input  logic [31:0] ctl,
   input  logic [31:0] acc_addr,
   input  logic [7:0]  acc_lanes,
   input  logic        acc_store,
   input  logic        acc_priv,
   output logic        match
);
   import dwb_pkg::*;

   wctl_t      c;
   logic       qual_ok;
   logic       mask_rsv;
   logic       exact_hit;
   logic       region_hit;
   logic [7:0] wlanes;
   logic [7:0] judged;

   assign c = wctl_t'(ctl);

   assign qual_ok = c.en
                  & (acc_store ? c.ldst[1] : c.ldst[0])
                  & (acc_priv ? c.priv_en[1] : c.priv_en[0]);

   assign mask_rsv = (c.mask == 5'd1) || (c.mask == 5'd2);

   // exact compare: double-word plus lane overlap
   assign judged = val[2] ? {4'b0000, c.lane_sel[3:0]} : c.lane_sel;
   assign wlanes = val[2] ? {c.lane_sel[3:0], 4'b0000} : c.lane_sel;
   assign exact_hit = lanes_valid(judged)
                    && (acc_addr[31:3] == val[31:3])
                    && ((acc_lanes & wlanes) != '0);

   if (SUPPORT_MASK) begin : g_region
      logic [31:0] keep;
      assign keep = ~((32'h1 << c.mask) - 32'h1);
      assign region_hit = ((acc_addr ^ val) & keep) == '0;
   end else begin : g_noregion
      assign region_hit = 1'b0;
   end

   always_comb begin
      if (!qual_ok || mask_rsv)   match = 1'b0;
      else if (c.mask == 5'd0)    match = exact_hit;
      else                        match = region_hit;
   end

endmodule

// File: rtl/dwb_bank.sv
module dwb_bank #(
   parameter int NUM_WP       = 16,
   parameter bit SUPPORT_MASK = 1'b1,
   localparam int IDX_W       = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_kind,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              acc_valid,
   input  logic [31:0]       acc_addr,
   input  logic [1:0]        acc_size,
   input  logic              acc_store,
   input  logic              acc_priv,
   output logic [NUM_WP-1:0] hit_vec,
   output logic              hit_any
);
   import dwb_pkg::*;

   if (NUM_WP < 1 || NUM_WP > 16) begin : g_bad_count
      $error("dwb_bank: NUM_WP must lie in 1..16");
   end

   logic [NUM_WP-1:0][31:0] val_q;
   logic [NUM_WP-1:0][31:0] ctl_q;
   logic [NUM_WP-1:0]       match;
   logic [7:0]              acc_lanes;

   dwb_regs #(.NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .kind  (reg_kind),
      .idx   (reg_idx),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .val_q (val_q),
      .ctl_q (ctl_q)
   );

   assign acc_lanes = touched_lanes(acc_size, acc_addr[2:0]);

   for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
      dwb_slot #(.SUPPORT_MASK(SUPPORT_MASK)) u_slot (
         .val       (val_q[g]),
         .ctl       (ctl_q[g]),
         .acc_addr  (acc_addr),
         .acc_lanes (acc_lanes),
         .acc_store (acc_store),
         .acc_priv  (acc_priv),
         .match     (match[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_vec <= '0;
         hit_any <= 1'b0;
      end else begin
         hit_vec <= acc_valid ? match : '0;
         hit_any <= acc_valid & (|match);
      end
   end

endmodule

// File: rtl/dwb_bank_chk.sv
module dwb_bank_chk #(
   parameter int NUM_WP = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    acc_valid,
   input logic                    acc_store,
   input logic                    acc_priv,
   input logic [NUM_WP-1:0]       hit_vec,
   input logic                    hit_any,
   input logic [NUM_WP-1:0][31:0] ctl_q
);

   // R11
   any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_any == (|hit_vec));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (hit_vec == '0));

   for (genvar g = 0; g < NUM_WP; g++) begin : g_chk
      // R3
      off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && !ctl_q[g][0]) |=> !hit_vec[g]);

      // R9
      ldst_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && (acc_store ? !ctl_q[g][4] : !ctl_q[g][3])) |=> !hit_vec[g]);

      // R10
      priv_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && (acc_priv ? !ctl_q[g][2] : !ctl_q[g][1])) |=> !hit_vec[g]);

      // R8
      mask_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && (ctl_q[g][28:24] == 5'd1 || ctl_q[g][28:24] == 5'd2))
         |=> !hit_vec[g]);
   end

endmodule

bind dwb_bank dwb_bank_chk #(.NUM_WP(NUM_WP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_store (acc_store),
   .acc_priv  (acc_priv),
   .hit_vec   (hit_vec),
   .hit_any   (hit_any),
   .ctl_q     (ctl_q)
);

// File: tb/dwb_bank_bench.sv
module dwb_bank_bench;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_kind = 1'b0;
   logic [3:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic        acc_store = 1'b0;
   logic        acc_priv = 1'b0;
   logic [N-1:0] hit_vec;
   logic        hit_any;

   int checks = 0;
   int errors = 0;
   logic [31:0] mv [N];
   logic [31:0] mc [N];

   always #10 clk = ~clk;

   dwb_bank #(.NUM_WP(N)) u_dwb_bank (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_kind(reg_kind),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
      .acc_store(acc_store), .acc_priv(acc_priv),
      .hit_vec(hit_vec), .hit_any(hit_any)
   );

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic [31:0] mkctl(int mask, int lanes, int ldst, int priv, int en);
      return (32'(mask) << 24) | (32'(lanes) << 5) | (32'(ldst) << 3)
           | (32'(priv) << 1) | 32'(en);
   endfunction

   function automatic bit runs_ok(logic [7:0] b);
      int ones = 0;
      int runs = 0;
      for (int k = 0; k < 8; k++) begin
         if (b[k]) begin
            ones++;
            if (k == 0 || !b[k-1]) runs++;
         end
      end
      return (ones > 0) && (runs == 1);
   endfunction

   function automatic bit exp_hit(int i, logic [31:0] a, int sz, bit st, bit pv);
      logic [31:0] v = mv[i];
      logic [31:0] c = mc[i];
      int m = int'(c[28:24]);
      int off = int'(a[2:0]);
      logic [7:0] bas = c[12:5];
      bit h = 0;
      if (!c[0]) return 0;
      if (st ? !c[4] : !c[3]) return 0;
      if (pv ? !c[2] : !c[1]) return 0;
      if (m == 1 || m == 2) return 0;
      if (m >= 3) return (a >> m) == (v >> m);
      if (!runs_ok(v[2] ? {4'b0, bas[3:0]} : bas)) return 0;
      if (a[31:3] != v[31:3]) return 0;
      for (int b = 0; b < 8; b++) begin
         bit t = (b >= off) && (b < off + (1 << sz));
         bit w = v[2] ? (b >= 4 && bas[b-4]) : bas[b];
         if (t && w) h = 1;
      end
      return h;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int idx, bit kind, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_kind = kind; reg_idx = 4'(idx); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (kind) mc[idx] = d & 32'h1F1F_FFFF;
      else      mv[idx] = d;
   endtask

   task automatic rd_chk(int idx, bit kind, logic [31:0] exp, string req);
      @(negedge clk);
      reg_kind = kind; reg_idx = 4'(idx);
      #1;
      chk(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   task automatic clear_all();
      for (int i = 0; i < N; i++) wr(i, 1'b1, 32'h0);
   endtask

   // one access; compares the whole vector and the any flag
   task automatic acc(logic [31:0] a, int sz, bit st, bit pv, string req);
      logic [N-1:0] e = '0;
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_size = 2'(sz);
      acc_store = st; acc_priv = pv;
      for (int i = 0; i < N; i++) e[i] = exp_hit(i, a, sz, st, pv);
      @(negedge clk);
      acc_valid = 1'b0;
      chk(hit_vec == e && hit_any == (|e), req, 32'(hit_vec), 32'(e));
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin mv[i] = '0; mc[i] = '0; end
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < N; i += 5) begin
         rd_chk(i, 1'b0, 32'h0, "R1");
         rd_chk(i, 1'b1, 32'h0, "R1");
      end
      acc(32'h0, 3, 0, 1, "R1");

      // R2 read-back masking
      wr(3, 1'b1, 32'hFFFF_FFFF);
      rd_chk(3, 1'b1, 32'h1F1F_FFFF, "R2");
      wr(3, 1'b0, 32'hDEAD_BEEF);
      rd_chk(3, 1'b0, 32'hDEAD_BEEF, "R2");
      clear_all();

      // R4 exact lane compare
      wr(0, 1'b0, 32'h1000_0000);
      wr(0, 1'b1, mkctl(0, 8'h0C, 3, 3, 1));
      acc(32'h1000_0002, 0, 0, 0, "R4");
      acc(32'h1000_0004, 0, 0, 0, "R4");
      acc(32'h1000_0001, 0, 0, 0, "R4");
      acc(32'h1000_0000, 2, 1, 1, "R4");
      acc(32'h1000_0008, 3, 0, 0, "R4");

      // R5 upper word selection
      wr(0, 1'b0, 32'h1000_0004);
      wr(0, 1'b1, mkctl(0, 8'hF1, 3, 3, 1));
      acc(32'h1000_0004, 0, 0, 0, "R5");
      acc(32'h1000_0000, 0, 0, 0, "R5");
      acc(32'h1000_0005, 0, 0, 0, "R5");

      // R6 reserved lane selects
      wr(0, 1'b0, 32'h1000_0000);
      wr(0, 1'b1, mkctl(0, 8'h05, 3, 3, 1));
      acc(32'h1000_0000, 3, 0, 0, "R6");
      wr(0, 1'b1, mkctl(0, 8'h00, 3, 3, 1));
      acc(32'h1000_0000, 3, 0, 0, "R6");

      // R7 region masks
      wr(1, 1'b0, 32'h2000_0000);
      wr(1, 1'b1, mkctl(12, 8'h00, 3, 3, 1));
      acc(32'h2000_0FFF, 0, 0, 0, "R7");
      acc(32'h2000_1000, 0, 0, 0, "R7");
      wr(1, 1'b1, mkctl(31, 8'h00, 3, 3, 1));
      acc(32'h7FFF_FFFF, 0, 1, 0, "R7");
      acc(32'h8000_0000, 0, 1, 0, "R7");

      // R8 reserved masks
      wr(1, 1'b1, mkctl(1, 8'h0F, 3, 3, 1));
      acc(32'h2000_0000, 0, 0, 0, "R8");
      rd_chk(1, 1'b1, mkctl(1, 8'h0F, 3, 3, 1), "R8");
      wr(1, 1'b1, mkctl(2, 8'h0F, 3, 3, 1));
      acc(32'h2000_0000, 0, 0, 0, "R8");

      // R3 enable off
      wr(2, 1'b0, 32'h3000_0000);
      wr(2, 1'b1, mkctl(0, 8'hFF, 3, 3, 0));
      acc(32'h3000_0000, 3, 0, 0, "R3");

      // R9 load/store filter
      wr(2, 1'b1, mkctl(0, 8'hFF, 1, 3, 1));
      acc(32'h3000_0000, 0, 0, 0, "R9");
      acc(32'h3000_0000, 0, 1, 0, "R9");
      wr(2, 1'b1, mkctl(0, 8'hFF, 2, 3, 1));
      acc(32'h3000_0000, 0, 1, 0, "R9");
      acc(32'h3000_0000, 0, 0, 0, "R9");
      wr(2, 1'b1, mkctl(0, 8'hFF, 0, 3, 1));
      acc(32'h3000_0000, 0, 1, 0, "R9");

      // R10 privilege filter
      wr(2, 1'b1, mkctl(0, 8'hFF, 3, 1, 1));
      acc(32'h3000_0000, 0, 0, 0, "R10");
      acc(32'h3000_0000, 0, 0, 1, "R10");
      wr(2, 1'b1, mkctl(0, 8'hFF, 3, 2, 1));
      acc(32'h3000_0000, 0, 0, 1, "R10");
      acc(32'h3000_0000, 0, 0, 0, "R10");

      // R11 no strobe, no hit
      @(negedge clk);
      acc_addr = 32'h3000_0000; acc_priv = 1'b1; acc_valid = 1'b0;
      @(negedge clk);
      chk(hit_vec == '0 && !hit_any, "R11", 32'(hit_vec), 32'h0);

      // random programs and accesses, R4 R7 R9 R10
      for (int round = 0; round < 6; round++) begin
         for (int i = 0; i < N; i++) begin
            int r = int'($urandom % 8);
            int mk = (r < 5) ? 0 : (r == 5) ? 1 + int'($urandom % 2) : 3 + int'($urandom % 12);
            int s = int'($urandom % 8);
            int len = 1 + int'($urandom % (8 - s));
            int lanes = ($urandom % 6 == 0) ? int'($urandom % 256) : (((1 << len) - 1) << s);
            wr(i, 1'b0, 32'h4000_0000 + 32'(($urandom % 64) * 4));
            wr(i, 1'b1, mkctl(mk, lanes, int'($urandom % 4), int'($urandom % 4),
                              ($urandom % 8) != 0));
         end
         for (int k = 0; k < 60; k++) begin
            logic [31:0] a = ($urandom % 10 == 0) ? $urandom
                           : 32'h4000_0000 + 32'($urandom % 300);
            acc(a, int'($urandom % 4), 1'($urandom), 1'($urandom), "R4");
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule